// File: doc/BRIEF.md
# Debug Breakpoint Trigger Unit

This block watches core bus activity and emits a one-cycle breakpoint trigger when a programmed condition occurs. Two comparator channels look at the buses. Channel 1 compares a programmed address against the program address bus or the data address bus. Channel 2 compares against the program address bus, or compares a masked 8-, 16- or 32-bit value on the core data bus. Each channel match is qualified by the kind of access: instruction fetch, data access, any access, or never.

A combiner turns the two channel results into one occurrence. It can use either channel alone, their OR, their AND in the same cycle, or a sequence in which channel 1 matches first and channel 2 matches in a later cycle. An optional occurrence counter then holds the trigger back until the Nth occurrence of the combined condition. Software configures the unit through a simple write-only register port.

The combiner is a three-state machine. **OFF**: the unit is disabled. **IDLE**: enabled, no sequence in progress. **ARMED**: channel 1 has matched in sequence mode. The transitions are as follows. OFF→IDLE when enabled. IDLE→OFF and ARMED→OFF when disabled. IDLE→ARMED on a channel 1 match in sequence mode. ARMED→IDLE on a channel 2 match, which completes the sequence, or when the mode is no longer sequence. Any register write forces IDLE.

Top module: `bkpt_trigger`

## Requirements
- R1: After reset every configuration register reads as zero internally, so the unit is disabled and `trig` stays low. Register offsets on `cfg_addr` are: 0 control, 1 channel 1 address, 2 channel 2 reference (the low address bits when channel 2 compares an address, the full word when it compares data), 3 channel 2 data mask (1 = bit compared), 4 occurrence count N (low 16 bits). The control bits are: bit 0 enable, bits 3:1 combine code, bit 4 channel 1 source, bits 6:5 channel 1 qualifier, bit 7 channel 2 source, bits 9:8 channel 2 qualifier, bits 11:10 data width, bit 12 count enable.
- R2: Channel 1 matches when the selected bus equals its programmed address. A source of 0 selects the program address bus (`p_addr`) and a source of 1 selects the data address bus (`x_addr`). Activity on the bus that is not selected never matches.
- R3: Qualifier encodings are 0 fetch (`p_fetch` only), 1 data access (read or write strobe), 2 any (fetch, read or write) and 3 never. On the data bus there are no fetches, so qualifier 0 never matches there.
- R4: With source 1, channel 2 matches when `d_data` equals the reference on every bit that is set in the mask and inside the width window. Width code 0 compares bits 7:0, code 1 compares bits 15:0, and codes 2 and 3 compare all 32 bits. The match is qualified by `x_rd`/`x_wr`. With source 0, channel 2 compares `p_addr` with the reference, qualified on the program bus.
- R5: Combine code 0 uses channel 1 alone, code 1 uses channel 2 alone and code 2 is the OR of the two channels. Codes 5 to 7 never fire.
- R6: Combine code 3 (AND) fires only when both channels match in the same cycle.
- R7: Combine code 4 (sequence) fires when channel 2 matches in a cycle after the one in which channel 1 armed it. Each completion needs a fresh channel 1 match. A channel 2 match in the cycle of the arming channel 1 match does not complete the sequence.
- R8: With count enabled the trigger fires on the Nth occurrence, then the count restarts so that it fires again after N more. N = 0 behaves as N = 1.
- R9: The occurrence count applies to the combined expression, not to each channel separately.
- R10: A register write clears the occurrence count and the sequence-armed state. Bus activity in the cycle of a write is ignored.
- R11: While enable is 0, no trigger fires.
- R12: `trig` rises exactly one clock after the qualifying bus cycle and lasts one cycle per occurrence. Back-to-back occurrences give back-to-back pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| p_addr | input | 24 | Program address bus |
| p_fetch | input | 1 | Instruction fetch on the program bus |
| p_rd | input | 1 | Data read from program memory |
| p_wr | input | 1 | Data write to program memory |
| x_addr | input | 24 | Data address bus |
| x_rd | input | 1 | Data memory read |
| x_wr | input | 1 | Data memory write |
| d_data | input | 32 | Core data bus value |
| trig | output | 1 | Breakpoint trigger pulse |

## Verification
Each check drives one bus cycle against the expected trigger level for that cycle. Address patterns differ in a single low bit, or put the right address on the wrong bus, which separates source selection from the compare itself. Data patterns differ only inside or only outside the width window or the mask, which shows that these bound the compare. Channel events are placed alone, together in one cycle, and in both orders across cycles, which distinguishes OR, AND and sequence behaviour and the same-cycle corner of the sequence. Trains of repeated occurrences, interrupted by register writes and disables, expose counter reload, the N = 0 case, and the clearing of count and armed state.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] REG_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] REG_C1REF = 3'd1;
    localparam logic [REG_AW-1:0] REG_C2REF = 3'd2;
    localparam logic [REG_AW-1:0] REG_C2MSK = 3'd3;
    localparam logic [REG_AW-1:0] REG_COUNT = 3'd4;

    typedef enum logic [1:0] {
        Q_FETCH  = 2'd0,
        Q_ACCESS = 2'd1,
        Q_ANY    = 2'd2,
        Q_NEVER  = 2'd3
    } qual_e;

    localparam logic [2:0] CMB_CH1 = 3'd0;
    localparam logic [2:0] CMB_CH2 = 3'd1;
    localparam logic [2:0] CMB_OR  = 3'd2;
    localparam logic [2:0] CMB_AND = 3'd3;
    localparam logic [2:0] CMB_SEQ = 3'd4;

    localparam logic [1:0] DW_8  = 2'd0;
    localparam logic [1:0] DW_16 = 2'd1;

    // packed from msb to lsb so that the layout equals the control word bits
    typedef struct packed {
        logic       cnt_en;   // 12
        logic [1:0] dw;       // 11:10
        qual_e      c2_q;     // 9:8
        logic       c2_src;   // 7
        qual_e      c1_q;     // 6:5
        logic       c1_src;   // 4
        logic [2:0] comb;     // 3:1
        logic       en;       // 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic qual_hit(qual_e q, logic f, logic r, logic w);
        logic ok;
        case (q)
            Q_FETCH:  ok = f;
            Q_ACCESS: ok = r | w;
            Q_ANY:    ok = f | r | w;
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/bkpt_cfg_regs.sv
module bkpt_cfg_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [REG_AW-1:0]     cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    output ctrl_t                 ctrl,
    output logic [ADDR_W-1:0]     c1_ref,
    output logic [DATA_W-1:0]     c2_ref,
    output logic [DATA_W-1:0]     c2_mask,
    output logic [CNT_W-1:0]      cnt_n
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= '0;
            c1_ref  <= '0;
            c2_ref  <= '0;
            c2_mask <= '0;
            cnt_n   <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                REG_CTRL:  ctrl    <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                REG_C1REF: c1_ref  <= cfg_wdata[ADDR_W-1:0];
                REG_C2REF: c2_ref  <= cfg_wdata;
                REG_C2MSK: c2_mask <= cfg_wdata;
                REG_COUNT: cnt_n   <= cfg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bkpt_addr_chan.sv
module bkpt_addr_chan
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              use_data,
    input  qual_e             qual,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic [ADDR_W-1:0] p_addr,
    input  logic              p_fetch,
    input  logic              p_rd,
    input  logic              p_wr,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic              x_rd,
    input  logic              x_wr,
    output logic              hit
);

    always_comb begin
        if (use_data) begin
            // the data bus carries no fetches
            hit = (x_addr == ref_addr) && qual_hit(qual, 1'b0, x_rd, x_wr);
        end else begin
            hit = (p_addr == ref_addr) && qual_hit(qual, p_fetch, p_rd, p_wr);
        end
    end

endmodule

// File: rtl/bkpt_data_chan.sv
module bkpt_data_chan
    import bkpt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        dw,
    input  qual_e             qual,
    input  logic [DATA_W-1:0] ref_val,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] data,
    input  logic              rd,
    input  logic              wr,
    output logic              hit
);

    logic [DATA_W-1:0] win;
    logic [DATA_W-1:0] diff;

    for (genvar i = 0; i < DATA_W; i++) begin : g_win
        if (i < 8) begin : g_b
            assign win[i] = 1'b1;
        end else if (i < 16) begin : g_h
            assign win[i] = (dw != DW_8);
        end else begin : g_w
            assign win[i] = (dw != DW_8) && (dw != DW_16);
        end
    end

    assign diff = (data ^ ref_val) & mask & win;
    assign hit  = (diff == '0) && qual_hit(qual, 1'b0, rd, wr);

endmodule

// File: rtl/bkpt_combiner.sv
module bkpt_combiner
    import bkpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             en,
    input  logic [2:0]       comb,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] cnt_n,
    input  logic             m1,
    input  logic             m2,
    output logic             trig
);

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_ARMED = 2'd2
    } st_e;

    localparam logic [CNT_W:0] ONE = 1;

    st_e              state, state_nx;
    logic             seq_mode;
    logic             active;
    logic             ev;
    logic             last;
    logic             fire;
    logic [CNT_W-1:0] hits;
    logic [CNT_W:0]   n_eff;
    logic [CNT_W:0]   hits_inc;

    assign seq_mode = (comb == CMB_SEQ);
    assign active   = (state != ST_OFF) && en && !cfg_we;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (en) state_nx = ST_IDLE;
            end
            ST_IDLE: begin
                if (!en)                  state_nx = ST_OFF;
                else if (seq_mode && m1)  state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (!en)                  state_nx = ST_OFF;
                else if (!seq_mode)       state_nx = ST_IDLE;
                else if (m2)              state_nx = ST_IDLE;
            end
            default: state_nx = ST_OFF;
        endcase
        if (cfg_we) state_nx = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // combined occurrence
    always_comb begin
        unique case (comb)
            CMB_CH1: ev = m1;
            CMB_CH2: ev = m2;
            CMB_OR:  ev = m1 | m2;
            CMB_AND: ev = m1 & m2;
            CMB_SEQ: ev = (state == ST_ARMED) && m2;
            default: ev = 1'b0;
        endcase
    end

    // occurrence counter
    assign n_eff    = (cnt_n == '0) ? ONE : {1'b0, cnt_n};
    assign hits_inc = {1'b0, hits} + ONE;
    assign last     = !cnt_en || (hits_inc >= n_eff);
    assign fire     = active && ev && last;

    always_ff @(posedge clk) begin
        if (!rst_n || cfg_we || !en) begin
            hits <= '0;
        end else if (active && ev && cnt_en) begin
            hits <= last ? '0 : hits_inc[CNT_W-1:0];
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) trig <= 1'b0;
        else        trig <= fire;
    end

    a_r12_trig_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(m1 || m2));
    a_r10_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !trig);
    a_r11_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cfg_we) |=> !trig);
    a_r7_seq_was_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && seq_mode) |-> $past(state == ST_ARMED));
    a_r6_and_both: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && comb == CMB_AND) |-> $past(m1 && m2));
    a_r8_hits_bound: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, hits} < n_eff);

endmodule

// File: rtl/bkpt_trigger.sv
module bkpt_trigger
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] p_addr,
    input  logic              p_fetch,
    input  logic              p_rd,
    input  logic              p_wr,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic              x_rd,
    input  logic              x_wr,
    input  logic [DATA_W-1:0] d_data,
    output logic              trig
);

    ctrl_t             ctl;
    logic [ADDR_W-1:0] c1_ref;
    logic [DATA_W-1:0] c2_ref;
    logic [DATA_W-1:0] c2_mask;
    logic [CNT_W-1:0]  cnt_n;
    logic              m1;
    logic              m2;
    logic              m2_prog;
    logic              m2_data;

    bkpt_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ctrl      (ctl),
        .c1_ref    (c1_ref),
        .c2_ref    (c2_ref),
        .c2_mask   (c2_mask),
        .cnt_n     (cnt_n)
    );

    bkpt_addr_chan #(.ADDR_W(ADDR_W)) u_ch1 (
        .use_data (ctl.c1_src),
        .qual     (ctl.c1_q),
        .ref_addr (c1_ref),
        .p_addr   (p_addr),
        .p_fetch  (p_fetch),
        .p_rd     (p_rd),
        .p_wr     (p_wr),
        .x_addr   (x_addr),
        .x_rd     (x_rd),
        .x_wr     (x_wr),
        .hit      (m1)
    );

    bkpt_addr_chan #(.ADDR_W(ADDR_W)) u_ch2_prog (
        .use_data (1'b0),
        .qual     (ctl.c2_q),
        .ref_addr (c2_ref[ADDR_W-1:0]),
        .p_addr   (p_addr),
        .p_fetch  (p_fetch),
        .p_rd     (p_rd),
        .p_wr     (p_wr),
        .x_addr   (x_addr),
        .x_rd     (x_rd),
        .x_wr     (x_wr),
        .hit      (m2_prog)
    );

    bkpt_data_chan #(.DATA_W(DATA_W)) u_ch2_data (
        .dw      (ctl.dw),
        .qual    (ctl.c2_q),
        .ref_val (c2_ref),
        .mask    (c2_mask),
        .data    (d_data),
        .rd      (x_rd),
        .wr      (x_wr),
        .hit     (m2_data)
    );

    assign m2 = ctl.c2_src ? m2_data : m2_prog;

    bkpt_combiner #(.CNT_W(CNT_W)) u_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_we (cfg_we),
        .en     (ctl.en),
        .comb   (ctl.comb),
        .cnt_en (ctl.cnt_en),
        .cnt_n  (cnt_n),
        .m1     (m1),
        .m2     (m2),
        .trig   (trig)
    );

    a_r3_data_side_access: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.c1_src && m1) |-> (x_rd || x_wr));
    a_r4_value_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.c2_src && m2) |-> (x_rd || x_wr));

endmodule

// File: tb/bkpt_trigger_bench.sv
`timescale 1ns/1ps
module bkpt_trigger_bench;

    localparam int AW = 24;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [AW-1:0] p_addr = '0;
    logic          p_fetch = 1'b0, p_rd = 1'b0, p_wr = 1'b0;
    logic [AW-1:0] x_addr = '0;
    logic          x_rd = 1'b0, x_wr = 1'b0;
    logic [DW-1:0] d_data = '0;
    logic          trig;

    always #2 clk = ~clk;

    bkpt_trigger u_bkpt_trigger (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .p_addr(p_addr), .p_fetch(p_fetch),
        .p_rd(p_rd), .p_wr(p_wr), .x_addr(x_addr), .x_rd(x_rd),
        .x_wr(x_wr), .d_data(d_data), .trig(trig)
    );

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t q[$];
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // staged inputs for the next cycle
    logic          s_we;
    logic [2:0]    s_wa;
    logic [DW-1:0] s_wd;
    logic [AW-1:0] s_pa, s_xa;
    logic          s_pf, s_prd, s_pwr, s_xrd, s_xwr;
    logic [DW-1:0] s_d;

    task automatic clear_stage();
        s_we = 0; s_wa = '0; s_wd = '0; s_pa = '0; s_xa = '0;
        s_pf = 0; s_prd = 0; s_pwr = 0; s_xrd = 0; s_xwr = 0; s_d = '0;
    endtask

    // driver: one bus cycle, expected trigger for that cycle queued
    task automatic cyc(logic exp, string tag);
        item_t it;
        @(negedge clk);
        cfg_we = s_we; cfg_addr = s_wa; cfg_wdata = s_wd;
        p_addr = s_pa; p_fetch = s_pf; p_rd = s_prd; p_wr = s_pwr;
        x_addr = s_xa; x_rd = s_xrd; x_wr = s_xwr; d_data = s_d;
        it.exp = exp; it.tag = tag;
        q.push_back(it);
        clear_stage();
    endtask

    task automatic wr(logic [2:0] a, logic [DW-1:0] d);
        s_we = 1; s_wa = a; s_wd = d;
        cyc(1'b0, "R10");
    endtask

    // kind: 0 fetch, 1 read, 2 write
    task automatic prog(logic [AW-1:0] a, int kind, logic exp, string tag);
        s_pa = a; s_pf = (kind == 0); s_prd = (kind == 1); s_pwr = (kind == 2);
        cyc(exp, tag);
    endtask

    // kind: 0 no strobe, 1 read, 2 write
    task automatic dat(logic [AW-1:0] a, logic [DW-1:0] d, int kind, logic exp, string tag);
        s_xa = a; s_d = d; s_xrd = (kind == 1); s_xwr = (kind == 2);
        cyc(exp, tag);
    endtask

    function automatic logic [DW-1:0] mk(int en, int comb, int c1s, int c1q,
                                         int c2s, int c2q, int dw, int cnt);
        return DW'(en) | DW'(comb << 1) | DW'(c1s << 4) | DW'(c1q << 5) |
               DW'(c2s << 7) | DW'(c2q << 8) | DW'(dw << 10) | DW'(cnt << 12);
    endfunction

    // monitor: compares each cycle's trigger after the capturing edge
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                it = q.pop_front();
                n_run++;
                if (trig !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: trig=%0b expected=%0b at %0t", it.tag, trig, it.exp, $time);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R12: watchdog expired, trig=%0b expected=end of run", trig);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        clear_stage();
        // R1: reset holds trigger low
        repeat (3) @(posedge clk);
        #1;
        n_run++;
        if (trig !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: trig=%0b expected=0 in reset", trig);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: disabled after reset, address 0 fetch gives nothing
        prog(24'h0, 0, 1'b0, "R1");

        // R2/R3: channel 1 on program bus, fetch qualifier
        wr(3'd1, 32'h100);
        wr(3'd0, mk(1, 0, 0, 0, 0, 0, 0, 0));
        prog(24'h100, 0, 1'b1, "R2");
        prog(24'h100, 1, 1'b0, "R3");
        prog(24'h101, 0, 1'b0, "R2");
        dat(24'h100, 0, 2, 1'b0, "R2");
        // access qualifier
        wr(3'd0, mk(1, 0, 0, 1, 0, 0, 0, 0));
        prog(24'h100, 0, 1'b0, "R3");
        prog(24'h100, 1, 1'b1, "R3");
        prog(24'h100, 2, 1'b1, "R3");
        // any qualifier
        wr(3'd0, mk(1, 0, 0, 2, 0, 0, 0, 0));
        prog(24'h100, 0, 1'b1, "R3");
        prog(24'h100, 2, 1'b1, "R3");
        // never qualifier
        wr(3'd0, mk(1, 0, 0, 3, 0, 0, 0, 0));
        prog(24'h100, 0, 1'b0, "R3");
        // channel 1 on data address bus
        wr(3'd0, mk(1, 0, 1, 1, 0, 0, 0, 0));
        dat(24'h100, 0, 1, 1'b1, "R2");
        prog(24'h100, 0, 1'b0, "R2");
        wr(3'd0, mk(1, 0, 1, 0, 0, 0, 0, 0));
        dat(24'h100, 0, 1, 1'b0, "R3");

        // R4: channel 2 data value, widths and mask
        wr(3'd2, 32'h12345678);
        wr(3'd3, 32'hFFFFFFFF);
        wr(3'd0, mk(1, 1, 0, 0, 1, 2, 0, 0));
        dat(24'h0, 32'hAAAAAA78, 2, 1'b1, "R4");
        dat(24'h0, 32'hAAAAAA79, 2, 1'b0, "R4");
        wr(3'd0, mk(1, 1, 0, 0, 1, 2, 1, 0));
        dat(24'h0, 32'hAAAA5678, 2, 1'b1, "R4");
        dat(24'h0, 32'hAAAA4678, 2, 1'b0, "R4");
        wr(3'd0, mk(1, 1, 0, 0, 1, 2, 2, 0));
        dat(24'h0, 32'h12345678, 1, 1'b1, "R4");
        dat(24'h0, 32'h02345678, 1, 1'b0, "R4");
        wr(3'd3, 32'hFFFFFF0F);
        dat(24'h0, 32'h12345608, 2, 1'b1, "R4");
        dat(24'h0, 32'h12345678, 0, 1'b0, "R4");
        // channel 2 on program address
        wr(3'd2, 32'h200);
        wr(3'd0, mk(1, 1, 0, 0, 0, 0, 0, 0));
        prog(24'h200, 0, 1'b1, "R4");
        prog(24'h201, 0, 1'b0, "R4");

        // common channel setup
        wr(3'd1, 32'h100);
        wr(3'd2, 32'h55);
        wr(3'd3, 32'hFF);

        // R5: OR
        wr(3'd0, mk(1, 2, 0, 0, 1, 2, 0, 0));
        prog(24'h100, 0, 1'b1, "R5");
        dat(24'h0, 32'h55, 2, 1'b1, "R5");
        dat(24'h0, 32'h56, 2, 1'b0, "R5");
        s_pa = 24'h100; s_pf = 1;
        dat(24'h0, 32'h55, 2, 1'b1, "R5");
        // R5: reserved code
        wr(3'd0, mk(1, 5, 0, 0, 1, 2, 0, 0));
        prog(24'h100, 0, 1'b0, "R5");

        // R6: AND on data address and value
        wr(3'd1, 32'h40);
        wr(3'd0, mk(1, 3, 1, 1, 1, 1, 0, 0));
        dat(24'h40, 32'h55, 2, 1'b1, "R6");
        dat(24'h41, 32'h55, 2, 1'b0, "R6");
        dat(24'h40, 32'h56, 2, 1'b0, "R6");

        // R7: sequence
        wr(3'd1, 32'h100);
        wr(3'd0, mk(1, 4, 0, 0, 1, 2, 0, 0));
        dat(24'h0, 32'h55, 2, 1'b0, "R7");
        prog(24'h100, 0, 1'b0, "R7");
        cyc(1'b0, "R7");
        dat(24'h0, 32'h55, 2, 1'b1, "R7");
        dat(24'h0, 32'h55, 2, 1'b0, "R7");
        s_pa = 24'h100; s_pf = 1;
        dat(24'h0, 32'h55, 2, 1'b0, "R7");
        dat(24'h0, 32'h55, 2, 1'b1, "R7");
        // R10: a write drops the armed state
        prog(24'h100, 0, 1'b0, "R7");
        wr(3'd0, mk(1, 4, 0, 0, 1, 2, 0, 0));
        dat(24'h0, 32'h55, 2, 1'b0, "R10");

        // R8: Nth occurrence with reload
        wr(3'd4, 32'd3);
        wr(3'd0, mk(1, 0, 0, 0, 0, 0, 0, 1));
        for (int k = 0; k < 2; k++) begin
            prog(24'h100, 0, 1'b0, "R8");
            prog(24'h100, 0, 1'b0, "R8");
            prog(24'h100, 0, 1'b1, "R8");
        end
        wr(3'd4, 32'd0);
        prog(24'h100, 0, 1'b1, "R8");
        prog(24'h100, 0, 1'b1, "R8");
        wr(3'd4, 32'd1);
        prog(24'h100, 0, 1'b1, "R8");

        // R9: count on combined OR expression
        wr(3'd4, 32'd2);
        wr(3'd0, mk(1, 2, 0, 0, 1, 2, 0, 1));
        prog(24'h100, 0, 1'b0, "R9");
        dat(24'h0, 32'h55, 2, 1'b1, "R9");
        dat(24'h0, 32'h55, 2, 1'b0, "R9");
        prog(24'h100, 0, 1'b1, "R9");

        // R10: write clears count, activity during write ignored
        wr(3'd4, 32'd3);
        wr(3'd0, mk(1, 0, 0, 0, 0, 0, 0, 1));
        prog(24'h100, 0, 1'b0, "R10");
        prog(24'h100, 0, 1'b0, "R10");
        wr(3'd4, 32'd3);
        prog(24'h100, 0, 1'b0, "R10");
        prog(24'h100, 0, 1'b0, "R10");
        s_pa = 24'h100; s_pf = 1;
        wr(3'd4, 32'd3);
        prog(24'h100, 0, 1'b0, "R10");
        prog(24'h100, 0, 1'b0, "R10");
        prog(24'h100, 0, 1'b1, "R10");

        // R11: disabled
        wr(3'd0, mk(0, 0, 0, 0, 0, 0, 0, 0));
        prog(24'h100, 0, 1'b0, "R11");
        prog(24'h100, 0, 1'b0, "R11");

        // R12: back-to-back pulses, then low
        wr(3'd0, mk(1, 0, 0, 0, 0, 0, 0, 0));
        prog(24'h100, 0, 1'b1, "R12");
        prog(24'h100, 0, 1'b1, "R12");
        cyc(1'b0, "R12");

        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule